// File: doc/BRIEF.md
# Cascaded Interrupt Controller Command Decoder

This block sits behind the byte write path of a pair of cascaded programmable interrupt controllers, one main and one secondary. Each controller has two ports. The block watches every write and keeps track of how far each controller is through its initialization command sequence. It stores the four initialization words.

Once a controller has finished initialization, writes are sent to one of three places: the interrupt mask register, the end-of-interrupt command register, or the read-select command register. A specific end-of-interrupt command raises a one-cycle pulse. A byte that is not legal for the controller's current state raises a one-cycle error pulse and leaves every stored register unchanged.

Each controller has its own chip select, so the two controllers sequence independently. Priority resolution and vector generation are left to other logic.

Top module: `intc_cmd_decoder`

## Requirements
- R1: On port 0, a byte with bit 4 set is an initialization word 1. It is stored in `icw1_o` in any state, `ready_o` drops, and the controller then waits for word 2.
- R2: While waiting for word 2, a port-1 write is stored in `icw2_o`. If bit 1 of word 1 (single mode) is 0, the controller waits for word 3 next. If it is 1, word 3 is skipped, and the controller goes to word 4 when bit 0 of word 1 is 1, or straight to ready when it is 0.
- R3: While waiting for word 3, a port-1 write is stored in `icw3_o`. The controller then waits for word 4 if bit 0 of word 1 is 1, and otherwise becomes ready.
- R4: While waiting for word 4, a port-1 write is stored in `icw4_o` and the controller becomes ready.
- R5: When ready, a port-1 write loads `mask_o`. Before the controller is ready, `mask_o` never changes.
- R6: When ready, a port-0 byte with bits 4:3 = 00, bit 7 = 0, bit 6 = 1 and bit 5 = 1 is a specific end-of-interrupt. It is stored in `ocw2_o`, and `eoi_o` is high for the single cycle after the write.
- R7: When ready, a port-0 byte with bits 4:3 = 01 is stored in `ocw3_o`.
- R8: Three kinds of write are illegal: a port-0 write that is not word 1 while the controller is not ready, a port-1 write before any word 1, and a command with bits 4:3 = 00 that is not a specific end-of-interrupt. An illegal write raises `err_o` for one cycle and changes no stored register.
- R9: A write reaches only the controller whose `cs` bit is set. The other controller's outputs do not change.
- R10: Reset returns both controllers to uninitialized, clears all stored registers including the masks, and holds `eoi_o`, `err_o` and `ready_o` low.
- R11: All outputs are registered. A write sampled on one clock edge is visible from that edge until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| cs | input | NCTL | Controller select, bit 0 = main, bit 1 = secondary |
| port_sel | input | 1 | Port select, 0 = command port, 1 = data port |
| wr_data | input | DW | Write byte |
| icw1_o | output | NCTL x DW | Stored initialization word 1 per controller |
| icw2_o | output | NCTL x DW | Stored initialization word 2 per controller |
| icw3_o | output | NCTL x DW | Stored initialization word 3 per controller |
| icw4_o | output | NCTL x DW | Stored initialization word 4 per controller |
| mask_o | output | NCTL x DW | Interrupt mask per controller |
| ocw2_o | output | NCTL x DW | Last specific end-of-interrupt command per controller |
| ocw3_o | output | NCTL x DW | Read-select command per controller |
| ready_o | output | NCTL | Controller has finished initialization |
| eoi_o | output | NCTL | One-cycle specific end-of-interrupt pulse |
| err_o | output | NCTL | One-cycle illegal-write pulse |

## Verification
The bench runs each skip path of the sequence in turn:
- single mode with word 4,
- single mode without word 4,
- cascade mode with word 4,
- cascade mode without word 4.

A decoder that tests the wrong flag would store a later byte into the wrong word register, or leave the controller not ready. The bench writes the mask before initialization and issues a non-specific end-of-interrupt; a decoder that does not reject these would change the mask or `ocw2_o` instead of pulsing the error. It restarts word 1 in the middle of a sequence. It also checks that the unselected controller stays unchanged, which would catch crossed chip selects.

// File: rtl/intc_pkg.sv
package intc_pkg;
   typedef enum logic [2:0] {
      ST_UNINIT = 3'd0,
      ST_WAIT2  = 3'd1,
      ST_WAIT3  = 3'd2,
      ST_WAIT4  = 3'd3,
      ST_READY  = 3'd4
   } seq_t;

   typedef enum logic [1:0] {
      CMD_INIT  = 2'd0,
      CMD_EOI   = 2'd1,
      CMD_RDSEL = 2'd2
   } cmd_t;

   // bit positions the decoder depends on
   localparam int B_IC4    = 0;
   localparam int B_SINGLE = 1;
   localparam int B_SEL    = 3;
   localparam int B_INIT   = 4;
   localparam int B_EOI    = 5;
   localparam int B_SL     = 6;
   localparam int B_ROT    = 7;
   localparam int MIN_DW   = 8;
endpackage

// File: rtl/intc_cmd_classify.sv
module intc_cmd_classify
   import intc_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic [DW-1:0] byte_i,
   output cmd_t          cmd_o,
   output logic          spec_eoi_o
);
   always_comb begin
      if (byte_i[B_INIT])     cmd_o = CMD_INIT;
      else if (byte_i[B_SEL]) cmd_o = CMD_RDSEL;
      else                    cmd_o = CMD_EOI;
   end

   assign spec_eoi_o = byte_i[B_EOI] & byte_i[B_SL] & ~byte_i[B_ROT];
endmodule

// File: rtl/intc_seq_ctrl.sv
module intc_seq_ctrl
   import intc_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_i,
   input  logic          port_i,
   input  logic [DW-1:0] data_i,
   output logic [DW-1:0] icw1_o,
   output logic [DW-1:0] icw2_o,
   output logic [DW-1:0] icw3_o,
   output logic [DW-1:0] icw4_o,
   output logic [DW-1:0] mask_o,
   output logic [DW-1:0] ocw2_o,
   output logic [DW-1:0] ocw3_o,
   output logic          ready_o,
   output logic          eoi_o,
   output logic          err_o
);
   seq_t st_q;
   cmd_t cmd;
   logic spec_eoi;
   seq_t after_w2;
   seq_t after_w3;

   intc_cmd_classify #(.DW(DW)) u_cls (
      .byte_i     (data_i),
      .cmd_o      (cmd),
      .spec_eoi_o (spec_eoi)
   );

   always_comb begin
      after_w3 = icw1_o[B_IC4] ? ST_WAIT4 : ST_READY;
      after_w2 = icw1_o[B_SINGLE] ? after_w3 : ST_WAIT3;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_UNINIT;
         icw1_o <= '0;
         icw2_o <= '0;
         icw3_o <= '0;
         icw4_o <= '0;
         mask_o <= '0;
         ocw2_o <= '0;
         ocw3_o <= '0;
         eoi_o  <= 1'b0;
         err_o  <= 1'b0;
      end else begin
         eoi_o <= 1'b0;
         err_o <= 1'b0;
         if (wr_i) begin
            if (!port_i) begin
               if (cmd == CMD_INIT) begin
                  icw1_o <= data_i;
                  st_q   <= ST_WAIT2;
               end else if (st_q == ST_READY && cmd == CMD_RDSEL) begin
                  ocw3_o <= data_i;
               end else if (st_q == ST_READY && cmd == CMD_EOI && spec_eoi) begin
                  ocw2_o <= data_i;
                  eoi_o  <= 1'b1;
               end else begin
                  err_o <= 1'b1;
               end
            end else begin
               unique case (st_q)
                  ST_WAIT2: begin
                     icw2_o <= data_i;
                     st_q   <= after_w2;
                  end
                  ST_WAIT3: begin
                     icw3_o <= data_i;
                     st_q   <= after_w3;
                  end
                  ST_WAIT4: begin
                     icw4_o <= data_i;
                     st_q   <= ST_READY;
                  end
                  ST_READY: mask_o <= data_i;
                  default:  err_o  <= 1'b1;
               endcase
            end
         end
      end
   end

   assign ready_o = (st_q == ST_READY);
endmodule

// File: rtl/intc_cmd_decoder.sv
module intc_cmd_decoder
   import intc_pkg::*;
#(
   parameter int NCTL = 2,
   parameter int DW   = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [NCTL-1:0]          cs,
   input  logic                     port_sel,
   input  logic [DW-1:0]            wr_data,
   output logic [NCTL-1:0][DW-1:0]  icw1_o,
   output logic [NCTL-1:0][DW-1:0]  icw2_o,
   output logic [NCTL-1:0][DW-1:0]  icw3_o,
   output logic [NCTL-1:0][DW-1:0]  icw4_o,
   output logic [NCTL-1:0][DW-1:0]  mask_o,
   output logic [NCTL-1:0][DW-1:0]  ocw2_o,
   output logic [NCTL-1:0][DW-1:0]  ocw3_o,
   output logic [NCTL-1:0]          ready_o,
   output logic [NCTL-1:0]          eoi_o,
   output logic [NCTL-1:0]          err_o
);
   generate
      if (DW < MIN_DW) begin : g_bad_dw
         $error("intc_cmd_decoder: DW must be at least 8");
      end
      if (NCTL < 1) begin : g_bad_nctl
         $error("intc_cmd_decoder: NCTL must be at least 1");
      end
   endgenerate

   for (genvar gi = 0; gi < NCTL; gi++) begin : g_ctl
      intc_seq_ctrl #(.DW(DW)) u_seq (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_i    (wr_en & cs[gi]),
         .port_i  (port_sel),
         .data_i  (wr_data),
         .icw1_o  (icw1_o[gi]),
         .icw2_o  (icw2_o[gi]),
         .icw3_o  (icw3_o[gi]),
         .icw4_o  (icw4_o[gi]),
         .mask_o  (mask_o[gi]),
         .ocw2_o  (ocw2_o[gi]),
         .ocw3_o  (ocw3_o[gi]),
         .ready_o (ready_o[gi]),
         .eoi_o   (eoi_o[gi]),
         .err_o   (err_o[gi])
      );
   end
endmodule

// File: rtl/intc_cmd_decoder_chk.sv
module intc_cmd_decoder_chk #(
   parameter int NCTL = 2,
   parameter int DW   = 8
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     wr_en,
   input logic [NCTL-1:0]          cs,
   input logic                     port_sel,
   input logic [DW-1:0]            wr_data,
   input logic [NCTL-1:0][DW-1:0]  icw1_o,
   input logic [NCTL-1:0][DW-1:0]  icw2_o,
   input logic [NCTL-1:0][DW-1:0]  icw3_o,
   input logic [NCTL-1:0][DW-1:0]  icw4_o,
   input logic [NCTL-1:0][DW-1:0]  mask_o,
   input logic [NCTL-1:0][DW-1:0]  ocw2_o,
   input logic [NCTL-1:0][DW-1:0]  ocw3_o,
   input logic [NCTL-1:0]          ready_o,
   input logic [NCTL-1:0]          eoi_o,
   input logic [NCTL-1:0]          err_o
);
   for (genvar gi = 0; gi < NCTL; gi++) begin : g_chk
      AST_INIT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && cs[gi] && !port_sel && wr_data[4]) |=>
            (!ready_o[gi] && icw1_o[gi] == $past(wr_data))); // R1

      AST_MASK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
         !ready_o[gi] |=> $stable(mask_o[gi])); // R5

      AST_EOI_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
         eoi_o[gi] |-> ready_o[gi]); // R6

      AST_ERR_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
         err_o[gi] |-> ($stable(icw1_o[gi]) && $stable(icw2_o[gi]) && $stable(icw3_o[gi])
                        && $stable(icw4_o[gi]) && $stable(mask_o[gi])
                        && $stable(ocw2_o[gi]) && $stable(ocw3_o[gi]))); // R8

      AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
         !(eoi_o[gi] && err_o[gi])); // R8

      AST_UNSELECTED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         !(wr_en && cs[gi]) |=> (!eoi_o[gi] && !err_o[gi] && $stable(mask_o[gi]))); // R9
   end
endmodule

bind intc_cmd_decoder intc_cmd_decoder_chk #(.NCTL(NCTL), .DW(DW)) u_chk (.*);

// File: tb/intc_cmd_decoder_tb.sv
`timescale 1ns/1ps
module intc_cmd_decoder_tb_top;
   localparam int NCTL = 2;
   localparam int DW   = 8;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic                    wr_en = 1'b0;
   logic [NCTL-1:0]         cs = '0;
   logic                    port_sel = 1'b0;
   logic [DW-1:0]           wr_data = '0;
   logic [NCTL-1:0][DW-1:0] icw1_o, icw2_o, icw3_o, icw4_o, mask_o, ocw2_o, ocw3_o;
   logic [NCTL-1:0]         ready_o, eoi_o, err_o;

   always #2 clk = ~clk;

   intc_cmd_decoder #(.NCTL(NCTL), .DW(DW)) dut_i (.*);

   typedef struct {
      int         ctl;
      string      req;
      logic [7:0] r [7];
      logic       rdy;
      logic       eoi;
      logic       err;
   } exp_t;

   exp_t q[$];
   int   n_chk = 0;
   int   n_fail = 0;

   // reference model: state 0 none, 2/3/4 waiting for that word, 5 ready
   int         m_st [NCTL];
   logic [7:0] m_r  [NCTL][7];
   logic       m_eoi [NCTL];
   logic       m_err [NCTL];

   task automatic model_reset();
      for (int c = 0; c < NCTL; c++) begin
         m_st[c] = 0; m_eoi[c] = 0; m_err[c] = 0;
         for (int k = 0; k < 7; k++) m_r[c][k] = 8'h00;
      end
   endtask

   task automatic push_all(string req);
      for (int c = 0; c < NCTL; c++) begin
         exp_t e;
         e.ctl = c;
         e.req = req;
         for (int k = 0; k < 7; k++) e.r[k] = m_r[c][k];
         e.rdy = (m_st[c] == 5);
         e.eoi = m_eoi[c];
         e.err = m_err[c];
         q.push_back(e);
      end
   endtask

   task automatic model_write(int c, bit p, logic [7:0] d);
      for (int k = 0; k < NCTL; k++) begin m_eoi[k] = 0; m_err[k] = 0; end
      if (!p) begin
         if (d[4]) begin m_r[c][0] = d; m_st[c] = 2; end
         else if (m_st[c] == 5 && d[3]) m_r[c][6] = d;
         else if (m_st[c] == 5 && d[7:5] == 3'b011) begin m_r[c][5] = d; m_eoi[c] = 1; end
         else m_err[c] = 1;
      end else begin
         case (m_st[c])
            2: begin
               m_r[c][1] = d;
               if (!m_r[c][0][1]) m_st[c] = 3;
               else m_st[c] = m_r[c][0][0] ? 4 : 5;
            end
            3: begin m_r[c][2] = d; m_st[c] = m_r[c][0][0] ? 4 : 5; end
            4: begin m_r[c][3] = d; m_st[c] = 5; end
            5: m_r[c][4] = d;
            default: m_err[c] = 1;
         endcase
      end
   endtask

   // driver: one write per call, expected state of both controllers queued
   task automatic wr(int c, bit p, logic [7:0] d, string req);
      @(negedge clk);
      cs = '0;
      cs[c] = 1'b1;
      port_sel = p;
      wr_data = d;
      wr_en = 1'b1;
      @(posedge clk);
      #1;
      wr_en = 1'b0;
      cs = '0;
      model_write(c, p, d);
      push_all(req);
   endtask

   task automatic cmp(string req, int c, string f, logic [7:0] a, logic [7:0] e);
      n_chk++;
      if (a !== e) begin
         n_fail++;
         $display("FAIL %s ctl%0d %s actual=%h expected=%h", req, c, f, a, e);
      end
   endtask

   // monitor: compares every queued item against the outputs
   always @(negedge clk) begin
      while (q.size() > 0) begin
         exp_t e;
         string rq;
         e = q.pop_front();
         rq = (e.ctl == 0) ? e.req : {e.req, "/R9"};
         cmp(rq, e.ctl, "icw1",  icw1_o[e.ctl], e.r[0]);
         cmp(rq, e.ctl, "icw2",  icw2_o[e.ctl], e.r[1]);
         cmp(rq, e.ctl, "icw3",  icw3_o[e.ctl], e.r[2]);
         cmp(rq, e.ctl, "icw4",  icw4_o[e.ctl], e.r[3]);
         cmp(rq, e.ctl, "mask",  mask_o[e.ctl], e.r[4]);
         cmp(rq, e.ctl, "ocw2",  ocw2_o[e.ctl], e.r[5]);
         cmp(rq, e.ctl, "ocw3",  ocw3_o[e.ctl], e.r[6]);
         cmp(rq, e.ctl, "ready", {7'd0, ready_o[e.ctl]}, {7'd0, e.rdy});
         cmp(rq, e.ctl, "eoi",   {7'd0, eoi_o[e.ctl]},   {7'd0, e.eoi});
         cmp(rq, e.ctl, "err",   {7'd0, err_o[e.ctl]},   {7'd0, e.err});
      end
   end

   initial begin
      #(200000 * 4);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      model_reset();
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      push_all("R10_reset");
      // illegal writes before init: R8
      wr(0, 1, 8'hFF, "R8_mask_uninit");
      wr(0, 0, 8'h60, "R8_eoi_uninit");
      // main: cascade with word 4: R1 R2 R3 R4
      wr(0, 0, 8'h11, "R1_icw1");
      wr(0, 0, 8'h0B, "R8_ocw_midseq");
      wr(0, 1, 8'h20, "R2_icw2");
      wr(0, 1, 8'h04, "R3_icw3");
      wr(0, 1, 8'h01, "R4_icw4");
      wr(0, 1, 8'hFB, "R5_mask");
      wr(0, 0, 8'h62, "R6_spec_eoi");
      wr(0, 0, 8'h20, "R8_nonspec_eoi");
      wr(0, 0, 8'hE0, "R8_rotate_eoi");
      wr(0, 0, 8'h0B, "R7_ocw3");
      wr(0, 0, 8'h0A, "R7_ocw3_again");
      // secondary: single mode with word 4 skips word 3: R2
      wr(1, 0, 8'h13, "R1_sec_icw1");
      wr(1, 1, 8'h28, "R2_single_icw2");
      wr(1, 1, 8'h05, "R4_single_icw4");
      wr(1, 1, 8'hAA, "R5_sec_mask");
      // single mode without word 4: R2
      wr(1, 0, 8'h12, "R1_reinit");
      wr(1, 1, 8'h30, "R2_single_noic4");
      wr(1, 1, 8'h55, "R5_mask2");
      wr(1, 0, 8'h67, "R6_sec_eoi");
      // cascade without word 4: R3
      wr(0, 0, 8'h10, "R1_restart");
      wr(0, 1, 8'h11, "R5_mask_blocked");
      wr(0, 1, 8'h04, "R3_icw3_noic4");
      wr(0, 1, 8'h3C, "R5_mask3");
      // word 1 restart mid sequence: R1
      wr(0, 0, 8'h11, "R1_mid_a");
      wr(0, 1, 8'h40, "R2_mid");
      wr(0, 0, 8'h1B, "R1_mid_b");
      wr(0, 1, 8'h48, "R2_after_restart");
      wr(0, 1, 8'h01, "R4_after_restart");
      repeat (3) @(negedge clk);
      push_all("R11_pulses_clear");
      repeat (2) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule